// File: doc/BRIEF.md
# Register Front End for a Block-Cipher Core

This block is the bus-facing register file that sits in front of a 128-bit block-cipher engine. A host on a 32-bit memory-mapped slave port with a 5-bit word address loads a key and an input block, and then writes a control word. The control word states that the key and the data are valid and selects the direction of the operation. The front end then drives the engine through a start/done handshake and captures the 128-bit output in a result bank. It raises an interrupt when that result is ready.

The expanded key is retained from one operation to the next. Key expansion runs only on the first start after the key has been marked valid. Further encryptions or decryptions reuse the expansion until the host writes a control word with the key-valid bit clear. The bus port is locked against changes while an operation is running. Reads of the result bank are stretched with a wait signal until the new result is in place, and writes to the banks are dropped.

Top module: `cipher_regfront`

## Requirements
- R1: After reset, `irq` and `waitreq` are low and every register reads as zero, including the control register (address 31) and result word 16.
- R2: Key words sit at addresses 0 to KEY_BITS/32-1, and address 0 holds the most significant 32 bits of the key. The input block sits at addresses 8 to 11, and address 8 holds bits 127:96. Each of these words reads back the value written to it.
- R3: Writing to address 31 a value with bit 7 (key valid), bit 6 (data valid) and bit 0 set starts an encryption of the input block. The 128-bit result reads from addresses 16 to 19, and address 16 holds bits 127:96.
- R4: When decryption is built in, writing 0xC2 to the control register (bits 7, 6 and 1 set, bit 0 clear) starts a decryption. If bits 0 and 1 are both set, encryption is performed.
- R5: A control write in which bit 7 or bit 6 is clear starts no operation. The interrupt stays low and the result bank is not changed.
- R6: The first start after the key is marked valid issues a single key-expansion request and waits for its done flag before the cipher start. Later starts skip expansion and keep using that expansion, even if new key words have been written since.
- R7: Repeating a start command without changing anything gives an identical result. A new input block can be processed under the retained key without reloading the key.
- R8: A control write with bit 7 clear invalidates the expansion. The next valid start expands the key words that are currently in the key bank.
- R9: `irq` rises in the cycle after the engine reports completion and stays high. It is cleared by a control-register write or by an accepted read of any result word. It is never high while an operation is running.
- R10: `waitreq` is high for a read of addresses 16 to 19 while an operation is running, and low for every other access.
- R11: While an operation is running, writes to the key bank, the data bank and the control register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Slave select |
| addr | input | 5 | Word address |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid when `waitreq` is low |
| waitreq | output | 1 | Stalls a result-bank read while an operation runs |
| irq | output | 1 | Operation-complete interrupt |
| cx_key | output | KEY_BITS | Key to the engine, word 0 in the top bits |
| cx_blk_in | output | 128 | Input block to the engine |
| cx_kx_go | output | 1 | One-cycle key-expansion request |
| cx_kx_done | input | 1 | Key expansion finished |
| cx_go | output | 1 | One-cycle cipher start |
| cx_dec | output | 1 | Direction for the current operation, 1 for decrypt |
| cx_done | input | 1 | Cipher operation finished, output valid |
| cx_blk_out | input | 128 | Output block from the engine |

## Verification
The hardest situation to reach is bus traffic that arrives while an operation is in flight: result reads that must stall, and key, data or control writes that must be dropped. The bench reaches it with a stand-in engine whose latency is long enough that several bus accesses fit inside a single operation. It issues those accesses immediately after a start and then reads back the banks to confirm that they were not touched. A second hard case is a change to the key bank without invalidation. The result must then still reflect the old expansion, which the bench confirms by comparing against a value computed from the earlier key.

// File: rtl/cf_pkg.sv
package cf_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_KEXP = 2'd1,
    SQ_RUN  = 2'd2
  } sq_state_t;

  // control register bit positions
  localparam int CB_ENC = 0;
  localparam int CB_DEC = 1;
  localparam int CB_DAT = 6;
  localparam int CB_KEY = 7;

  // address map (word addresses)
  localparam int A_KEY0 = 0;
  localparam int A_DAT0 = 8;
  localparam int A_RES0 = 16;
  localparam int A_CTRL = 31;
endpackage

// File: rtl/cf_wordbank.sv
module cf_wordbank #(
  parameter int N  = 4,
  parameter int DW = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [IW-1:0]   widx,
  input  logic [DW-1:0]   wdata,
  input  logic [IW-1:0]   ridx,
  output logic [DW-1:0]   rword,
  output logic [N*DW-1:0] flat
);
  localparam logic [IW:0] NLIM = (IW + 1)'(N);

  logic [DW-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) mem[i] <= '0;
    end else if (we && ({1'b0, widx} < NLIM)) begin
      mem[widx] <= wdata;
    end
  end

  assign rword = ({1'b0, ridx} < NLIM) ? mem[ridx] : '0;

  // word 0 occupies the most significant slot
  for (genvar g = 0; g < N; g++) begin : g_flat
    assign flat[(N-1-g)*DW +: DW] = mem[g];
  end
endmodule

// File: rtl/cf_seq.sv
module cf_seq
  import cf_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic go_dec,
  input  logic kill,
  input  logic kx_done,
  input  logic op_done,
  output logic kx_start,
  output logic op_start,
  output logic dec,
  output logic busy,
  output logic done_evt
);
  sq_state_t st;
  logic kx_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SQ_IDLE;
      kx_ok    <= 1'b0;
      kx_start <= 1'b0;
      op_start <= 1'b0;
      dec      <= 1'b0;
    end else begin
      kx_start <= 1'b0;
      op_start <= 1'b0;
      case (st)
        SQ_IDLE: begin
          if (kill) kx_ok <= 1'b0;
          if (go) begin
            dec <= go_dec;
            if (kx_ok) begin
              op_start <= 1'b1;
              st       <= SQ_RUN;
            end else begin
              kx_start <= 1'b1;
              st       <= SQ_KEXP;
            end
          end
        end
        SQ_KEXP: begin
          if (kx_done) begin
            kx_ok    <= 1'b1;
            op_start <= 1'b1;
            st       <= SQ_RUN;
          end
        end
        SQ_RUN: begin
          if (op_done) st <= SQ_IDLE;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign busy     = (st != SQ_IDLE);
  assign done_evt = (st == SQ_RUN) && op_done;

  // R6: expansion request and cipher start are never issued together
  assert_kx_not_with_go_R6: assert property (@(posedge clk) disable iff (rst)
    kx_start |-> !op_start);

  // R6: finished expansion is followed by the cipher start
  assert_go_after_kx_R6: assert property (@(posedge clk) disable iff (rst)
    (st == SQ_KEXP && kx_done) |=> (op_start && st == SQ_RUN));
endmodule

// File: rtl/cipher_regfront.sv
module cipher_regfront
  import cf_pkg::*;
#(
  parameter int KEY_BITS    = 128,
  parameter bit HAS_DECRYPT = 1'b1,
  parameter int DW          = 32,
  parameter int AW          = 5,
  parameter int BLK_BITS    = 128
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cs,
  input  logic [AW-1:0]       addr,
  input  logic                wr,
  input  logic                rd,
  input  logic [DW-1:0]       wdata,
  output logic [DW-1:0]       rdata,
  output logic                waitreq,
  output logic                irq,
  output logic [KEY_BITS-1:0] cx_key,
  output logic [BLK_BITS-1:0] cx_blk_in,
  output logic                cx_kx_go,
  input  logic                cx_kx_done,
  output logic                cx_go,
  output logic                cx_dec,
  input  logic                cx_done,
  input  logic [BLK_BITS-1:0] cx_blk_out
);
  localparam int KW     = KEY_BITS / DW;
  localparam int BWORDS = BLK_BITS / DW;
  localparam int KIW    = $clog2(KW);
  localparam int BIW    = $clog2(BWORDS);
  localparam logic [AW-1:0] AD_KEND = AW'(A_KEY0 + KW);
  localparam logic [AW-1:0] AD_D0   = AW'(A_DAT0);
  localparam logic [AW-1:0] AD_DEND = AW'(A_DAT0 + BWORDS);
  localparam logic [AW-1:0] AD_R0   = AW'(A_RES0);
  localparam logic [AW-1:0] AD_REND = AW'(A_RES0 + BWORDS);
  localparam logic [AW-1:0] AD_CTL  = AW'(A_CTRL);

  logic busy, done_evt;
  logic key_hit, dat_hit, res_hit, ctl_hit;
  logic acc_w, key_we, dat_we, ctl_we, res_rd_ok;
  logic go, go_dec, kill, dec_req;
  logic [DW-1:0] key_rword, dat_rword;
  logic [7:0] ctrl_q;
  logic [BLK_BITS-1:0] res_q;
  logic [DW-1:0] res_w [BWORDS];

  // address decode
  assign key_hit = (addr < AD_KEND);
  assign dat_hit = (addr >= AD_D0) && (addr < AD_DEND);
  assign res_hit = (addr >= AD_R0) && (addr < AD_REND);
  assign ctl_hit = (addr == AD_CTL);

  assign acc_w  = cs && wr && !busy;
  assign key_we = acc_w && key_hit;
  assign dat_we = acc_w && dat_hit;
  assign ctl_we = acc_w && ctl_hit;

  // direction option
  if (HAS_DECRYPT) begin : g_dec
    assign dec_req = wdata[CB_DEC];
  end else begin : g_nodec
    assign dec_req = 1'b0;
  end

  assign go     = ctl_we && wdata[CB_KEY] && wdata[CB_DAT] && (wdata[CB_ENC] || dec_req);
  assign go_dec = !wdata[CB_ENC];
  assign kill   = ctl_we && !wdata[CB_KEY];

  assign waitreq   = cs && rd && res_hit && busy;
  assign res_rd_ok = cs && rd && res_hit && !busy;

  cf_wordbank #(.N(KW), .DW(DW)) u_key (
    .clk(clk), .rst(rst), .we(key_we), .widx(addr[KIW-1:0]), .wdata(wdata),
    .ridx(addr[KIW-1:0]), .rword(key_rword), .flat(cx_key)
  );

  cf_wordbank #(.N(BWORDS), .DW(DW)) u_dat (
    .clk(clk), .rst(rst), .we(dat_we), .widx(addr[BIW-1:0]), .wdata(wdata),
    .ridx(addr[BIW-1:0]), .rword(dat_rword), .flat(cx_blk_in)
  );

  cf_seq u_seq (
    .clk(clk), .rst(rst), .go(go), .go_dec(go_dec), .kill(kill),
    .kx_done(cx_kx_done), .op_done(cx_done), .kx_start(cx_kx_go),
    .op_start(cx_go), .dec(cx_dec), .busy(busy), .done_evt(done_evt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      res_q  <= '0;
      irq    <= 1'b0;
    end else begin
      if (ctl_we) ctrl_q <= wdata[7:0];
      if (done_evt) res_q <= cx_blk_out;
      if (done_evt) irq <= 1'b1;
      else if (ctl_we || res_rd_ok) irq <= 1'b0;
    end
  end

  for (genvar g = 0; g < BWORDS; g++) begin : g_res
    assign res_w[g] = res_q[(BWORDS-1-g)*DW +: DW];
  end

  always_comb begin
    rdata = '0;
    if (key_hit)      rdata = key_rword;
    else if (dat_hit) rdata = dat_rword;
    else if (res_hit) rdata = res_w[addr[BIW-1:0]];
    else if (ctl_hit) rdata = {{(DW-8){1'b0}}, ctrl_q};
  end

  // R11: key and data banks hold still during an operation
  assert_banks_frozen_R11: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(cx_key) && $stable(cx_blk_in)));

  // R5: a control word without both valid bits leaves the block idle
  assert_no_start_R5: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && !(wdata[CB_KEY] && wdata[CB_DAT])) |=> !busy);

  // R9: completion raises the interrupt
  assert_irq_on_done_R9: assert property (@(posedge clk) disable iff (rst)
    done_evt |=> irq);

  // R9: no interrupt while work is pending
  assert_irq_quiet_busy_R9: assert property (@(posedge clk) disable iff (rst)
    busy |-> !irq);

  // R10: a stalled result read does not clear the interrupt path
  assert_stall_keeps_busy_R10: assert property (@(posedge clk) disable iff (rst)
    (waitreq && !done_evt) |=> busy);
endmodule

// File: tb/sim_cipher_regfront.sv
`timescale 1ns/1ps
module sim_cipher_regfront;
  localparam int KB   = 128;
  localparam int OLAT = 16;
  localparam int KLAT = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic waitreq, irq;
  logic [KB-1:0] cx_key;
  logic [127:0] cx_blk_in, cx_blk_out;
  logic cx_kx_go, cx_kx_done, cx_go, cx_dec, cx_done;

  int checks = 0, fails = 0, kx_cnt = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cipher_regfront #(.KEY_BITS(KB), .HAS_DECRYPT(1'b1)) u0 (
    .clk(clk), .rst(rst), .cs(cs), .addr(addr), .wr(wr), .rd(rd),
    .wdata(wdata), .rdata(rdata), .waitreq(waitreq), .irq(irq),
    .cx_key(cx_key), .cx_blk_in(cx_blk_in), .cx_kx_go(cx_kx_go),
    .cx_kx_done(cx_kx_done), .cx_go(cx_go), .cx_dec(cx_dec),
    .cx_done(cx_done), .cx_blk_out(cx_blk_out)
  );

  function automatic logic [127:0] f_expand(input logic [127:0] k);
    return {k[63:0], k[127:64]} ^ 128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0;
  endfunction
  function automatic logic [127:0] f_enc(input logic [127:0] b, input logic [127:0] rk);
    logic [127:0] t;
    t = b ^ rk;
    return {t[114:0], t[127:115]};
  endfunction
  function automatic logic [127:0] f_dec(input logic [127:0] b, input logic [127:0] rk);
    return {b[12:0], b[127:13]} ^ rk;
  endfunction

  // behavioural stand-in engine
  logic [127:0] m_rk, m_blk;
  logic m_dec;
  int kx_t, op_t;
  always_ff @(posedge clk) begin
    if (rst) begin
      kx_t <= 0; op_t <= 0; cx_kx_done <= 1'b0; cx_done <= 1'b0;
      m_rk <= '0; m_blk <= '0; m_dec <= 1'b0; cx_blk_out <= '0;
    end else begin
      cx_kx_done <= 1'b0;
      cx_done    <= 1'b0;
      if (cx_kx_go) begin
        kx_t <= KLAT; m_rk <= f_expand(cx_key); kx_cnt <= kx_cnt + 1;
      end else if (kx_t != 0) begin
        kx_t <= kx_t - 1;
        if (kx_t == 1) cx_kx_done <= 1'b1;
      end
      if (cx_go) begin
        op_t <= OLAT; m_blk <= cx_blk_in; m_dec <= cx_dec;
      end else if (op_t != 0) begin
        op_t <= op_t - 1;
        if (op_t == 1) begin
          cx_done    <= 1'b1;
          cx_blk_out <= m_dec ? f_dec(m_blk, m_rk) : f_enc(m_blk, m_rk);
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr32(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd32(input logic [4:0] a, output logic [31:0] d, output int stalls);
    @(negedge clk);
    rd = 1'b1; addr = a;
    #1;
    stalls = 0;
    while (waitreq && stalls < 500) begin
      @(negedge clk); #1; stalls++;
    end
    d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic load_key(input logic [127:0] k);
    for (int i = 0; i < 4; i++) wr32(5'(i), k[127-32*i -: 32]);
  endtask
  task automatic load_data(input logic [127:0] b);
    for (int i = 0; i < 4; i++) wr32(5'(8+i), b[127-32*i -: 32]);
  endtask
  task automatic read_result(output logic [127:0] r);
    logic [31:0] w;
    int s;
    for (int i = 0; i < 4; i++) begin
      rd32(5'(16+i), w, s);
      r[127-32*i -: 32] = w;
    end
  endtask
  task automatic wait_irq();
    int n = 0;
    while (!irq && n < 300) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [127:0] k1, k2, k3, d1, d2, res, rk, junk;
    logic [31:0] w;
    int st, kc, sd;
    sd = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst = 1'b0; cs = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(!irq && !waitreq, "R1 irq/waitreq", {126'd0, irq, waitreq}, 0);
    rd32(5'd31, w, st); check(w == 0, "R1 ctrl", w, 0);
    rd32(5'd16, w, st); check(w == 0, "R1 result", w, 0);

    // R2 bank load and readback
    k1 = {$urandom, $urandom, $urandom, $urandom};
    d1 = {$urandom, $urandom, $urandom, $urandom};
    load_key(k1); load_data(d1);
    rd32(5'd0, w, st); check(w == k1[127:96], "R2 key word0", w, k1[127:96]);
    rd32(5'd3, w, st); check(w == k1[31:0], "R2 key word3", w, k1[31:0]);
    rd32(5'd8, w, st); check(w == d1[127:96], "R2 data word8", w, d1[127:96]);
    rd32(5'd11, w, st); check(w == d1[31:0], "R2 data word11", w, d1[31:0]);

    // R3/R6 first encryption with expansion
    rk = f_expand(k1);
    wr32(5'd31, 32'hC1);
    wait_irq();
    check(kx_cnt == 1, "R6 one expansion", kx_cnt, 1);
    repeat (5) @(negedge clk);
    check(irq, "R9 irq held", irq, 1);
    rd32(5'd16, w, st);
    check(!irq, "R9 irq cleared by result read", irq, 0);
    read_result(res);
    check(res == f_enc(d1, rk), "R3 encrypt", res, f_enc(d1, rk));

    // R7 repeat without changes
    wr32(5'd31, 32'hC1); wait_irq(); read_result(res);
    check(res == f_enc(d1, rk), "R7 repeat identical", res, f_enc(d1, rk));
    check(kx_cnt == 1, "R6 no re-expansion", kx_cnt, 1);

    // R4 decryption, and enc+dec both set picks encrypt
    wr32(5'd31, 32'hC2); wait_irq(); read_result(res);
    check(res == f_dec(d1, rk), "R4 decrypt", res, f_dec(d1, rk));
    load_data(f_enc(d1, rk));
    wr32(5'd31, 32'hC2); wait_irq(); read_result(res);
    check(res == d1, "R4 round trip", res, d1);
    load_data(d1);
    wr32(5'd31, 32'hC3); wait_irq();
    wr32(5'd31, 32'hC1);
    check(!irq, "R9 irq cleared by control write", irq, 0);
    wait_irq(); read_result(res);
    check(res == f_enc(d1, rk), "R4 both bits encrypt", res, f_enc(d1, rk));

    // R10/R11 traffic during an operation
    d2 = {$urandom, $urandom, $urandom, $urandom};
    load_data(d2);
    wr32(5'd31, 32'hC1);
    junk = {4{32'hDEADBEEF}};
    wr32(5'd8, junk[31:0]);
    wr32(5'd0, junk[31:0]);
    wr32(5'd31, 32'h0);
    rd32(5'd16, w, st);
    check(st > 0, "R10 result read stalls", st, 1);
    check(w == f_enc(d2, rk) >> 96, "R10 stalled read value", w, f_enc(d2, rk) >> 96);
    rd32(5'd8, w, st);
    check(w == d2[127:96], "R11 data write ignored", w, d2[127:96]);
    check(st == 0, "R10 no stall idle", st, 0);
    rd32(5'd0, w, st);
    check(w == k1[127:96], "R11 key write ignored", w, k1[127:96]);
    rd32(5'd31, w, st);
    check(w == 32'hC1, "R11 control write ignored", w, 32'hC1);

    // R5 incomplete control words
    kc = kx_cnt;
    rd32(5'd16, w, st);
    wr32(5'd31, 32'h41);
    repeat (30) @(negedge clk);
    check(!irq && kx_cnt == kc, "R5 no start key bit clear", irq, 0);
    wr32(5'd31, 32'h81);
    repeat (30) @(negedge clk);
    check(!irq && kx_cnt == kc, "R5 no start data bit clear", irq, 0);
    read_result(res);
    check(res == f_enc(d2, rk), "R5 result unchanged", res, f_enc(d2, rk));

    // R8 invalidated key, new key expanded
    k2 = {$urandom, $urandom, $urandom, $urandom};
    load_key(k2);
    wr32(5'd31, 32'hC1); wait_irq(); read_result(res);
    rk = f_expand(k2);
    check(kx_cnt == kc + 1, "R8 re-expansion", kx_cnt, kc + 1);
    check(res == f_enc(d2, rk), "R8 new key result", res, f_enc(d2, rk));

    // R6 key rewritten without invalidation keeps old expansion
    k3 = {$urandom, $urandom, $urandom, $urandom};
    load_key(k3);
    wr32(5'd31, 32'hC1); wait_irq(); read_result(res);
    check(res == f_enc(d2, rk), "R6 retained expansion", res, f_enc(d2, rk));

    // R7 random data and direction under retained key
    for (int i = 0; i < 16; i++) begin
      logic [127:0] dr, ex;
      logic dsel;
      dr = {$urandom, $urandom, $urandom, $urandom};
      dsel = 1'($urandom);
      load_data(dr);
      wr32(5'd31, dsel ? 32'hC2 : 32'hC1);
      wait_irq(); read_result(res);
      ex = dsel ? f_dec(dr, rk) : f_enc(dr, rk);
      check(res == ex, "R7 random block", res, ex);
    end
    check(kx_cnt == kc + 1, "R6 expansion count after random", kx_cnt, kc + 1);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule